// File: doc/BRIEF.md
# Vectored Interrupt Controller with Self-Clearing Acknowledge

This block collects interrupt requests from several peripheral sub-blocks and presents one request line to a processor core. Each source has a pending bit and an in-service bit. Some sources are single-event sources. Their pending bit is set by an event pulse and cleared by the acknowledge that selects them. The other sources are multiple-event sources. Each of these keeps a small event-flag register and a mask register, and its pending bit follows the OR of the unmasked flags.

The core acknowledges through a 16-bit vector register by writing its acknowledge bit. In that same edge, the controller snapshots the 5-bit code of the winning source into the vector field, marks that source in service, and clears its pending bit if it is a single-event source. The acknowledge bit reads back as 1 for one cycle and then clears itself. The handler retires the source by writing a one to its in-service bit. Register access is a plain single-cycle write strobe with a combinational read, so there is no streaming data path and no back-pressure.

Top module: `irq_vector_ctrl`

## Requirements
- R1: The vector register (address 0x930) holds the vector field in bits [15:11] and the acknowledge bit in bit [0]. Bits [10:1] always read zero. Writes to bits [15:1] have no effect.
- R2: Writing 1 to bit [0] of the vector register loads the vector field with index+1 of the lowest-index source that is pending and not in service. If no such source exists, the field is loaded with 0. Otherwise the field keeps its value.
- R3: After an acknowledge write, the acknowledge bit reads 1 for exactly one cycle and then reads 0.
- R4: A single-event source becomes pending when any of its event-input bits pulses. The acknowledge that selects it clears the pending bit.
- R5: A multiple-event source is pending exactly when its event flags ANDed with its mask (register at 0x980+2*i) are nonzero. An acknowledge does not clear it.
- R6: The event flags of a multiple-event source (register at 0x960+2*i) are set by its event inputs. Writing 1 to a flag clears it, and writing 0 leaves it unchanged.
- R7: The acknowledged source gets its in-service bit set (register 0x940, bit i). In-service sources are excluded from arbitration. Writing 1 to bit i at 0x940 clears that bit.
- R8: irq is high exactly when some source is pending and not in service.
- R9: After reset, all registers read zero and irq is low.
- R10: The pending register (0x942, bit i) is read-only. Writes to it do not change any pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_set | input | N_SRC*EVT_W | Event pulses; slice i belongs to source i |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 12 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Combinational read data at bus_addr |
| irq | output | 1 | Interrupt request to the core |

## Verification
The bench builds the block with N_SRC=6, EVT_W=4 and MULTI_MASK=6'b101000. Sources 3 and 5 are therefore multiple-event sources, and the other four are single-event sources. With this mix, one bench can exercise fixed-priority selection between single-event sources, exclusion of sources that are in service, and the empty-acknowledge code. The same bench also covers a masked event register whose pending bit survives the acknowledge and drops only once the flags are cleared by write-one.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int VN_W     = 5;
  localparam int REG_W    = 16;
  localparam int ADDR_W   = 12;
  localparam logic [ADDR_W-1:0] VEC_ADDR  = 12'h930;
  localparam logic [ADDR_W-1:0] INSV_ADDR = 12'h940;
  localparam logic [ADDR_W-1:0] PEND_ADDR = 12'h942;
  localparam logic [ADDR_W-1:0] EVT_BASE  = 12'h960;
  localparam logic [ADDR_W-1:0] MSK_BASE  = 12'h980;

  function automatic logic [VN_W-1:0] src_code(input int idx);
    return VN_W'(idx + 1);
  endfunction
endpackage

// File: rtl/vic_source.sv
module vic_source #(
  parameter int EVT_W    = 4,
  parameter bit IS_MULTI = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EVT_W-1:0] evt_in,
  input  logic             evt_wr,
  input  logic             msk_wr,
  input  logic [EVT_W-1:0] wdata,
  input  logic             ack_win,
  output logic             pend,
  output logic [EVT_W-1:0] evt_q,
  output logic [EVT_W-1:0] msk_q
);
  generate
    if (IS_MULTI) begin : g_multi
      logic [EVT_W-1:0] evt_r, msk_r;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          evt_r <= '0;
          msk_r <= '0;
        end else begin
          evt_r <= (evt_wr ? (evt_r & ~wdata) : evt_r) | evt_in;
          if (msk_wr) msk_r <= wdata;
        end
      end
      assign pend  = |(evt_r & msk_r);
      assign evt_q = evt_r;
      assign msk_q = msk_r;

      AST_MULTI_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_win && pend && !evt_wr && !msk_wr) |=> pend); // R5
    end else begin : g_single
      logic pend_r;
      always_ff @(posedge clk) begin
        if (!rst_n)          pend_r <= 1'b0;
        else if (|evt_in)    pend_r <= 1'b1;
        else if (ack_win)    pend_r <= 1'b0;
      end
      assign pend  = pend_r;
      assign evt_q = '0;
      assign msk_q = '0;

      AST_SINGLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_win && !(|evt_in)) |=> !pend); // R4
    end
  endgenerate
endmodule

// File: rtl/vic_arbiter.sv
module vic_arbiter
  import vic_pkg::*;
#(
  parameter int N_SRC = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] elig,
  output logic [N_SRC-1:0] grant,
  output logic [VN_W-1:0]  code
);
  always_comb begin
    grant = '0;
    code  = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (elig[i]) begin
        grant = '0;
        grant[i] = 1'b1;
        code = src_code(i);
      end
    end
  end

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && ((grant & ~elig) == '0)); // R2
  AST_EMPTY_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (elig == '0) |-> (code == '0)); // R2
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import vic_pkg::*;
#(
  parameter int             N_SRC      = 6,
  parameter int             EVT_W      = 4,
  parameter logic [N_SRC-1:0] MULTI_MASK = 6'b101000
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_SRC*EVT_W-1:0] evt_set,
  input  logic                   bus_wr,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic [REG_W-1:0]       bus_wdata,
  output logic [REG_W-1:0]       bus_rdata,
  output logic                   irq
);
  localparam int VN_LSB = REG_W - VN_W;

  logic [N_SRC-1:0] pend, insv, elig, grant, ack_win;
  logic [N_SRC-1:0] evt_wr, msk_wr;
  logic [EVT_W-1:0] evt_q [N_SRC];
  logic [EVT_W-1:0] msk_q [N_SRC];
  logic [VN_W-1:0]  code, vn_q;
  logic             ack_q, ack_fire, insv_wr;

  assign ack_fire = bus_wr && (bus_addr == VEC_ADDR) && bus_wdata[0] && !ack_q;
  assign insv_wr  = bus_wr && (bus_addr == INSV_ADDR);
  assign elig     = pend & ~insv;
  assign ack_win  = ack_fire ? grant : '0;
  assign irq      = |elig;

  genvar g;
  generate
    for (g = 0; g < N_SRC; g++) begin : g_src
      assign evt_wr[g] = bus_wr && (bus_addr == EVT_BASE + ADDR_W'(2 * g));
      assign msk_wr[g] = bus_wr && (bus_addr == MSK_BASE + ADDR_W'(2 * g));
      vic_source #(.EVT_W(EVT_W), .IS_MULTI(MULTI_MASK[g])) u_src (
        .clk(clk), .rst_n(rst_n),
        .evt_in(evt_set[g*EVT_W +: EVT_W]),
        .evt_wr(evt_wr[g]), .msk_wr(msk_wr[g]),
        .wdata(bus_wdata[EVT_W-1:0]),
        .ack_win(ack_win[g]),
        .pend(pend[g]), .evt_q(evt_q[g]), .msk_q(msk_q[g])
      );
    end
  endgenerate

  vic_arbiter #(.N_SRC(N_SRC)) u_arb (
    .clk(clk), .rst_n(rst_n), .elig(elig), .grant(grant), .code(code)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vn_q  <= '0;
      ack_q <= 1'b0;
      insv  <= '0;
    end else begin
      ack_q <= ack_fire;
      if (ack_fire) vn_q <= code;
      insv <= (insv_wr ? (insv & ~bus_wdata[N_SRC-1:0]) : insv) | ack_win;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == VEC_ADDR) begin
      bus_rdata[REG_W-1:VN_LSB] = vn_q;
      bus_rdata[0] = ack_q;
    end else if (bus_addr == INSV_ADDR) begin
      bus_rdata[N_SRC-1:0] = insv;
    end else if (bus_addr == PEND_ADDR) begin
      bus_rdata[N_SRC-1:0] = pend;
    end
    for (int i = 0; i < N_SRC; i++) begin
      if (bus_addr == EVT_BASE + ADDR_W'(2 * i)) bus_rdata[EVT_W-1:0] = evt_q[i];
      if (bus_addr == MSK_BASE + ADDR_W'(2 * i)) bus_rdata[EVT_W-1:0] = msk_q[i];
    end
  end

  AST_ACK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_q && !bus_wr) |=> !ack_q); // R3
  AST_VN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_fire |=> $stable(vn_q)); // R2
  AST_INSV_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_fire && (grant != '0)) |=> ((insv & $past(grant)) != '0)); // R7
  AST_PEND_RO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == PEND_ADDR && evt_set == '0 && !ack_fire &&
     (pend & MULTI_MASK) == '0) |=> $stable(pend)); // R10
endmodule

// File: tb/irq_vector_ctrl_test.sv
module irq_vector_ctrl_test;
  localparam int N = 6, EW = 4;
  logic clk = 0, rst_n = 0;
  logic [N*EW-1:0] evt_set = '0;
  logic bus_wr = 0;
  logic [11:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic irq;
  int checks = 0, errors = 0;

  irq_vector_ctrl #(.N_SRC(N), .EVT_W(EW), .MULTI_MASK(6'b101000)) uut (
    .clk(clk), .rst_n(rst_n), .evt_set(evt_set), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [15:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0; bus_wdata = '0;
  endtask

  task automatic rd_chk(input string req, input logic [11:0] a, input logic [15:0] exp);
    bus_addr = a; #1; chk(req, bus_rdata, exp);
  endtask

  task automatic pulse(input int src, input logic [EW-1:0] v);
    @(negedge clk); evt_set = '0; evt_set[src*EW +: EW] = v;
    @(negedge clk); evt_set = '0;
  endtask

  task automatic t_reset;
    rd_chk("R9 vec", 12'h930, 16'h0000);
    rd_chk("R9 insv", 12'h940, 16'h0000);
    rd_chk("R9 pend", 12'h942, 16'h0000);
    chk("R9 irq", 16'(irq), 16'h0000);
  endtask

  task automatic t_layout;
    wr(12'h930, 16'hFFFE);
    rd_chk("R1 ignored write", 12'h930, 16'h0000);
  endtask

  task automatic t_empty_ack;
    wr(12'h930, 16'h0001);
    rd_chk("R3 ack high", 12'h930, 16'h0001);
    @(negedge clk);
    rd_chk("R3 ack self-clear", 12'h930, 16'h0000);
  endtask

  task automatic t_priority;
    pulse(4, 4'b0001); pulse(1, 4'b1000);
    chk("R8 irq on pending", 16'(irq), 16'h0001);
    wr(12'h930, 16'h0001);
    rd_chk("R2 lowest wins", 12'h930, 16'h1001);
    rd_chk("R4 single cleared", 12'h942, 16'h0010);
    rd_chk("R7 insv set", 12'h940, 16'h0002);
    chk("R8 irq remaining", 16'(irq), 16'h0001);
    @(negedge clk);
    wr(12'h930, 16'h0001);
    @(negedge clk);
    rd_chk("R2 next source", 12'h930, 16'h2800);
    chk("R8 irq idle", 16'(irq), 16'h0000);
    wr(12'h940, 16'h0012);
    rd_chk("R7 insv cleared", 12'h940, 16'h0000);
  endtask

  task automatic t_exclusion;
    pulse(0, 4'b0010);
    wr(12'h930, 16'h0001);
    rd_chk("R2 source0", 12'h930, 16'h0801);
    pulse(0, 4'b0010);
    chk("R7 excluded irq", 16'(irq), 16'h0000);
    wr(12'h930, 16'h0001);
    rd_chk("R2 none eligible", 12'h930, 16'h0001);
    wr(12'h940, 16'h0001);
    chk("R8 irq after clear", 16'(irq), 16'h0001);
    wr(12'h930, 16'h0001);
    rd_chk("R2 source0 again", 12'h930, 16'h0801);
    wr(12'h940, 16'h0001);
  endtask

  task automatic t_multi;
    pulse(3, 4'b0110);
    chk("R5 masked no irq", 16'(irq), 16'h0000);
    rd_chk("R6 flags set", 12'h966, 16'h0006);
    wr(12'h986, 16'h0002);
    rd_chk("R5 pending unmasked", 12'h942, 16'h0008);
    wr(12'h930, 16'h0001);
    rd_chk("R2 multi code", 12'h930, 16'h2001);
    rd_chk("R5 survives ack", 12'h942, 16'h0008);
    wr(12'h940, 16'h0008);
    chk("R8 irq multi", 16'(irq), 16'h0001);
    wr(12'h966, 16'h0004);
    rd_chk("R6 w1c one bit", 12'h966, 16'h0002);
    wr(12'h966, 16'h0000);
    rd_chk("R6 zero no change", 12'h966, 16'h0002);
    wr(12'h966, 16'h0002);
    rd_chk("R6 cleared", 12'h966, 16'h0000);
    rd_chk("R5 pending drops", 12'h942, 16'h0000);
    chk("R8 irq low", 16'(irq), 16'h0000);
  endtask

  task automatic t_pend_ro;
    pulse(2, 4'b0001);
    wr(12'h942, 16'h003F);
    rd_chk("R10 pend unchanged", 12'h942, 16'h0004);
    wr(12'h942, 16'h0000);
    rd_chk("R10 pend not cleared", 12'h942, 16'h0004);
    wr(12'h930, 16'h0001);
    rd_chk("R4 ack clears src2", 12'h942, 16'h0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_layout();
    t_empty_ack();
    t_priority();
    t_exclusion();
    t_multi();
    t_pend_ro();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule